// File: doc/BRIEF.md
# Apparent Energy Accumulator with Readout

This block integrates apparent power over time. An upstream stage presents a signed 24-bit apparent power sample on `smp_i`. An internal strobe fires once every `STB_PERIOD` clocks, which is 5 by default. On each strobe the block adds the sample, with its sign, into a wide accumulator. The accumulator is 49 bits by default. The addition is signed even though apparent energy is normally positive, so a negative sample lowers the total.

A host reads the energy through a small register interface. It sees the accumulator divided by an 8-bit unsigned divisor, where a divisor of zero means no division. The host gets a 24-bit unsigned slice of the quotient. Two addresses return that slice. One only reads it. The other reads it and restarts the integration from zero. Two sticky status flags mark two events: the energy crossing its midpoint, and the energy wrapping past full scale. Each flag drives its own interrupt line through a separate enable bit.

Top module: `apparent_energy_acc`

## Requirements
- R1: On each internal strobe, the sign-extended sample is added to the `ACC_W`-bit two's complement accumulator, wrapping at its width. Between strobes the accumulator holds its value, and a negative sample decreases it.
- R2: The strobe repeats every `STB_PERIOD` clocks. The first strobe falls on the `STB_PERIOD`-th rising edge after reset is released.
- R3: The divisor register is 8 bits and unsigned. A value of 0 divides by 1, and any other value N divides the accumulator by N as a signed quotient truncated toward zero.
- R4: The energy value is bits `[ACC_W-2 : ACC_W-1-E_W]` of the quotient, which is bits 47:24 by default. The sign bit and the lower bits are dropped.
- R5: Register addresses are as follows. 0 returns the energy. 1 returns the energy and clears the accumulator. 2 holds the divisor in bits 7:0. 3 holds status, with bit 0 for half-full and bit 1 for overflow. 4 holds the interrupt enables, laid out like status. Any other address reads 0. Read data appears on `reg_rdata_o` on the clock edge that samples `reg_rd_i`, and it holds until the next read. All registers reset to 0.
- R6: A read of address 1 returns the energy from before the read and sets the accumulator to 0. If a strobe falls in the same cycle, the accumulator is loaded with that cycle's sample instead.
- R7: The half-full flag is set when the energy's top bit (bit 23) rises from 0 to 1.
- R8: The overflow flag is set when the energy's top bit falls from 1 to 0. A fall on the update that directly follows a clear-on-read does not set it.
- R9: Both flags are sticky. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R10: `irq_half_o` is high exactly when the half-full flag and enable bit 0 are both set. `irq_ovf_o` is high exactly when the overflow flag and enable bit 1 are both set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_i | input | SMP_W | Signed apparent power sample |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | DIV_W | Write data |
| reg_rdata_o | output | E_W | Registered read data |
| irq_half_o | output | 1 | Half-full interrupt |
| irq_ovf_o | output | 1 | Overflow interrupt |

## Verification
A sample taken on a strobe edge changes the energy right after that edge. A read issued in the following cycle therefore returns the new value on the edge that samples the read. A flag and its interrupt line change one edge after the energy's top bit crosses, which is two edges after the strobe that caused the crossing. The bench model steps on the same rising edges as the design, with one register stage per result. All comparisons happen on the falling edge, after both the model and the design have settled. Clear-on-read with a coincident strobe is placed deliberately by watching the model's strobe phase.

// File: rtl/aea_pkg.sv
package aea_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_ENERGY     = 3'd0,
        ADDR_ENERGY_CLR = 3'd1,
        ADDR_DIV        = 3'd2,
        ADDR_STAT       = 3'd3,
        ADDR_IEN        = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic ovf;
        logic half;
    } flags_t;

endpackage

// File: rtl/aea_strobe_gen.sv
module aea_strobe_gen #(
    parameter int PERIOD = 5
) (
    input  logic clk,
    input  logic rst_n,
    output logic stb_o
);
    localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stb_o = (st_q.cnt == LAST);

    generate
        if (PERIOD > 1) begin : g_spacing_chk
            assert_strobe_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
                stb_o |=> !stb_o);
        end
    endgenerate

endmodule

// File: rtl/aea_accum.sv
module aea_accum #(
    parameter int ACC_W = 49,
    parameter int SMP_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb_i,
    input  logic             clr_i,
    input  logic [SMP_W-1:0] smp_i,
    output logic [ACC_W-1:0] acc_o
);
    localparam int EXT_W = ACC_W - SMP_W;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } st_t;

    st_t st_d, st_q;
    logic [ACC_W-1:0] smp_ext;

    assign smp_ext = {{EXT_W{smp_i[SMP_W-1]}}, smp_i};

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.acc = stb_i ? smp_ext : '0;
        end else if (stb_i) begin
            st_d.acc = st_q.acc + smp_ext;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o = st_q.acc;

    assert_hold_between_strobes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!stb_i && !clr_i) |=> $stable(acc_o));

    assert_clear_to_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !stb_i) |=> (acc_o == '0));

endmodule

// File: rtl/aea_scale.sv
module aea_scale #(
    parameter int ACC_W = 49,
    parameter int E_W   = 24,
    parameter int DIV_W = 8
) (
    input  logic [ACC_W-1:0] acc_i,
    input  logic [DIV_W-1:0] div_i,
    output logic [E_W-1:0]   field_o
);
    localparam int LSB = ACC_W - 1 - E_W;

    logic signed [ACC_W-1:0] num;
    logic signed [ACC_W-1:0] den;
    logic signed [ACC_W-1:0] quo;

    always_comb begin
        num = $signed(acc_i);
        if (div_i == '0) begin
            den = ACC_W'(1);
        end else begin
            den = ACC_W'(div_i);
        end
        quo = num / den;
        field_o = E_W'(quo >> LSB);
    end

endmodule

// File: rtl/aea_regs.sv
module aea_regs
    import aea_pkg::*;
#(
    parameter int E_W   = 24,
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DIV_W-1:0]  wdata_i,
    input  logic [E_W-1:0]    field_i,
    output logic              clr_o,
    output logic [DIV_W-1:0]  div_o,
    output logic [E_W-1:0]    rdata_o,
    output logic              irq_half_o,
    output logic              irq_ovf_o
);
    typedef struct packed {
        logic             e_msb;
        logic             clr_pend;
        logic [DIV_W-1:0] div;
        flags_t           stat;
        flags_t           ien;
        logic [E_W-1:0]   rdata;
    } st_t;

    st_t st_d, st_q;
    logic set_half, set_ovf, stat_wr;
    logic [1:0] w1c;

    assign clr_o   = rd_i && (addr_i == ADDR_ENERGY_CLR);
    assign stat_wr = wr_i && (addr_i == ADDR_STAT);

    always_comb begin
        st_d = st_q;
        set_half = field_i[E_W-1] && !st_q.e_msb;
        set_ovf  = !field_i[E_W-1] && st_q.e_msb && !st_q.clr_pend;
        w1c      = stat_wr ? wdata_i[1:0] : 2'b00;

        st_d.e_msb     = field_i[E_W-1];
        st_d.clr_pend  = clr_o;
        st_d.stat.half = (st_q.stat.half && !w1c[0]) || set_half;
        st_d.stat.ovf  = (st_q.stat.ovf && !w1c[1]) || set_ovf;

        if (wr_i && (addr_i == ADDR_DIV)) begin
            st_d.div = wdata_i;
        end
        if (wr_i && (addr_i == ADDR_IEN)) begin
            st_d.ien = flags_t'(wdata_i[1:0]);
        end

        if (rd_i) begin
            case (addr_i)
                ADDR_ENERGY, ADDR_ENERGY_CLR: st_d.rdata = field_i;
                ADDR_DIV:                     st_d.rdata = E_W'(st_q.div);
                ADDR_STAT:                    st_d.rdata = E_W'(st_q.stat);
                ADDR_IEN:                     st_d.rdata = E_W'(st_q.ien);
                default:                      st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_o      = st_q.div;
    assign rdata_o    = st_q.rdata;
    assign irq_half_o = st_q.stat.half && st_q.ien.half;
    assign irq_ovf_o  = st_q.stat.ovf && st_q.ien.ovf;

    assert_half_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.stat.half) |-> st_q.e_msb);

    assert_ovf_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.stat.ovf) |-> (!st_q.e_msb && !$past(st_q.clr_pend)));

    assert_half_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.stat.half) |-> $past(stat_wr && wdata_i[0]));

    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.stat.ovf) |-> $past(stat_wr && wdata_i[1]));

endmodule

// File: rtl/apparent_energy_acc.sv
module apparent_energy_acc
    import aea_pkg::*;
#(
    parameter int ACC_W      = 49,
    parameter int SMP_W      = 24,
    parameter int E_W        = 24,
    parameter int DIV_W      = 8,
    parameter int STB_PERIOD = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SMP_W-1:0]  smp_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DIV_W-1:0]  reg_wdata_i,
    output logic [E_W-1:0]    reg_rdata_o,
    output logic              irq_half_o,
    output logic              irq_ovf_o
);
    logic             stb_w;
    logic             clr_w;
    logic [ACC_W-1:0] acc_w;
    logic [DIV_W-1:0] div_w;
    logic [E_W-1:0]   field_w;

    aea_strobe_gen #(.PERIOD(STB_PERIOD)) u_stb (
        .clk   (clk),
        .rst_n (rst_n),
        .stb_o (stb_w)
    );

    aea_accum #(.ACC_W(ACC_W), .SMP_W(SMP_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .stb_i (stb_w),
        .clr_i (clr_w),
        .smp_i (smp_i),
        .acc_o (acc_w)
    );

    aea_scale #(.ACC_W(ACC_W), .E_W(E_W), .DIV_W(DIV_W)) u_scale (
        .acc_i   (acc_w),
        .div_i   (div_w),
        .field_o (field_w)
    );

    aea_regs #(.E_W(E_W), .DIV_W(DIV_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (reg_wr_i),
        .rd_i       (reg_rd_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .field_i    (field_w),
        .clr_o      (clr_w),
        .div_o      (div_w),
        .rdata_o    (reg_rdata_o),
        .irq_half_o (irq_half_o),
        .irq_ovf_o  (irq_ovf_o)
    );

    assert_zero_acc_zero_field_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_w == '0) |-> (field_w == '0));

endmodule

// File: tb/apparent_energy_acc_tb_top.sv
module apparent_energy_acc_tb_top;
    localparam int ACC_W = 33;
    localparam int SMP_W = 24;
    localparam int E_W   = 24;
    localparam int DIV_W = 8;
    localparam int PER   = 5;
    localparam int LSB   = ACC_W - 1 - E_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [SMP_W-1:0] smp = '0;
    logic             reg_wr = 1'b0;
    logic             reg_rd = 1'b0;
    logic [2:0]       reg_addr = '0;
    logic [DIV_W-1:0] reg_wdata = '0;
    logic [E_W-1:0]   reg_rdata;
    logic             irq_half, irq_ovf;

    int tests = 0;
    int fails = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    // behavioural reference state
    int     m_cnt;
    longint m_acc;
    bit     m_emsb, m_clrp;
    int     m_div;
    bit [1:0] m_stat, m_ien;
    longint m_rdata;

    always #4 clk = ~clk;

    apparent_energy_acc #(.ACC_W(ACC_W), .SMP_W(SMP_W), .E_W(E_W),
                          .DIV_W(DIV_W), .STB_PERIOD(PER)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_i       (smp),
        .reg_wr_i    (reg_wr),
        .reg_rd_i    (reg_rd),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .irq_half_o  (irq_half),
        .irq_ovf_o   (irq_ovf)
    );

    function automatic longint wrapa(longint a);
        longint m = 64'sd1 <<< ACC_W;
        longint w = a & (m - 1);
        if (w >= (m >>> 1)) w = w - m;
        return w;
    endfunction

    function automatic longint fld(longint a, int d);
        longint dd = (d == 0) ? 1 : longint'(d);
        return ((a / dd) >> LSB) & 64'hFFFFFF;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_acc = 0; m_emsb = 0; m_clrp = 0;
            m_div = 0; m_stat = 0; m_ien = 0; m_rdata = 0;
        end else begin
            bit stb, clr, sh, so, nb;
            longint s, f;
            bit [1:0] w1c;
            stb = (m_cnt == PER - 1);
            s   = longint'($signed(smp));
            f   = fld(m_acc, m_div);
            clr = reg_rd && (reg_addr == 3'd1);
            nb  = f[E_W-1];
            sh  = nb && !m_emsb;
            so  = !nb && m_emsb && !m_clrp;
            w1c = (reg_wr && reg_addr == 3'd3) ? reg_wdata[1:0] : 2'b00;
            if (reg_rd) begin
                case (reg_addr)
                    3'd0, 3'd1: m_rdata = f;
                    3'd2:       m_rdata = m_div;
                    3'd3:       m_rdata = m_stat;
                    3'd4:       m_rdata = m_ien;
                    default:    m_rdata = 0;
                endcase
            end
            if (clr) m_acc = stb ? s : 0;
            else if (stb) m_acc = wrapa(m_acc + s);
            m_stat = (m_stat & ~w1c) | {so, sh};
            m_emsb = nb;
            m_clrp = clr;
            if (reg_wr && reg_addr == 3'd2) m_div = reg_wdata;
            if (reg_wr && reg_addr == 3'd4) m_ien = reg_wdata[1:0];
            m_cnt = stb ? 0 : m_cnt + 1;
        end
    end

    task automatic chk(string tag, longint act, longint exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R5 rdata per-cycle", reg_rdata, m_rdata);
            chk("R10 irq_half per-cycle", irq_half, m_stat[0] & m_ien[0]);
            chk("R10 irq_ovf per-cycle", irq_ovf, m_stat[1] & m_ien[1]);
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int a, int d);
        reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = DIV_W'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(int a);
        reg_rd = 1'b1; reg_addr = 3'(a);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_flag(int bitn, int limit);
        for (int i = 0; i < limit && !m_stat[bitn]; i++) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;

        // reset state
        rd(0); chk("R5 reset energy", reg_rdata, 0);
        rd(2); chk("R5 reset divisor", reg_rdata, 0);
        rd(3); chk("R5 reset status", reg_rdata, 0);
        rd(4); chk("R5 reset enables", reg_rdata, 0);
        rd(6); chk("R5 unmapped address", reg_rdata, 0);

        // strobe cadence: one field unit per strobe
        smp = 24'h000100;
        idle(20);
        rd(0); chk("R2 strobe cadence", reg_rdata, m_rdata);
        idle(3);
        rd(0); chk("R2 strobe cadence later", reg_rdata, m_rdata);

        // signed accumulation
        smp = 24'h000300;
        idle(20);
        rd(0); chk("R1 positive samples", reg_rdata, m_rdata);
        smp = 24'hFFFE00;
        idle(20);
        rd(0); chk("R1 negative samples", reg_rdata, m_rdata);
        smp = 24'h0;

        // divisor
        wr(2, 0); rd(0); chk("R3 divisor zero", reg_rdata, m_rdata);
        wr(2, 3); idle(2);
        rd(0); chk("R3 divisor three", reg_rdata, m_rdata);
        rd(2); chk("R5 divisor readback", reg_rdata, 3);
        wr(2, 0);

        // low-order bits dropped
        rd(1);
        smp = 24'h000001;
        idle(30);
        rd(0); chk("R4 sub-lsb energy", reg_rdata, 0);

        // clear-on-read away from strobe
        smp = 24'h000200;
        idle(12);
        while (m_cnt == PER - 1) @(negedge clk);
        rd(1); chk("R6 clear returns value", reg_rdata, m_rdata);
        rd(0); chk("R6 cleared", reg_rdata, 0);
        // clear-on-read coincident with strobe
        smp = 24'h000500;
        while (m_cnt != PER - 1) @(negedge clk);
        rd(1);
        rd(0); chk("R6 coincident sample kept", reg_rdata, 5);

        // half-full and overflow
        wr(4, 3);
        rd(1);
        smp = 24'h7FFFFF;
        wait_flag(0, 4000);
        idle(1);
        chk("R7 half-full irq", irq_half, 1);
        chk("R7 no overflow yet", irq_ovf, 0);
        wait_flag(1, 4000);
        idle(1);
        chk("R8 overflow irq", irq_ovf, 1);
        smp = 24'h0;
        rd(3); chk("R9 both flags sticky", reg_rdata, 3);
        wr(3, 1); rd(3); chk("R9 clear half only", reg_rdata, 2);
        wr(3, 0); rd(3); chk("R9 write zero no effect", reg_rdata, 2);
        wr(3, 2); rd(3); chk("R9 clear overflow", reg_rdata, 0);

        // clear-on-read drop does not count as overflow
        smp = 24'h7FFFFF;
        wait_flag(0, 4000);
        smp = 24'h0;
        rd(1);
        idle(3);
        rd(3); chk("R8 no overflow after clear", reg_rdata, 1);

        // enables gate the lines
        wr(4, 0); chk("R10 half masked", irq_half, 0);
        wr(4, 1); chk("R10 half enabled", irq_half, 1);
        chk("R10 ovf stays low", irq_ovf, 0);

        idle(2);
        cmp_on = 1'b0;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog R1 run did not complete actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule